// File: doc/BRIEF.md
# SPI chip-select and mode-fault controller

This block decides whether an SPI port is selected and handles its chip-select line in both the master and the slave role. Several register-style level inputs set how chip select behaves: a hardware output-drive enable, a software-select enable, a software select level and an error-interrupt enable. The port-enable and master bits are held inside the block. Software loads them with a control-write strobe, and the block itself can clear them.

When the port is a master that drives its own chip select, enabling the port pulls the line low. The line is released only after the port is disabled and the busy input shows that the transfer has ended. When the port is a master whose chip select is an input, a low effective select means another master has claimed the bus. The block then clears the enable and master bits, sets a sticky mode-fault flag, and can raise an interrupt. While the flag is set, software cannot turn the enable or master bits back on. Software removes the flag with a status access followed by a control write. In the slave role, the block reports the port as selected when the effective select is low.

The clock generator and the shift register are outside this block.

Top module: `spi_cs_ctrl`

## Requirements
- R1: With master=1, hw_cs_oe=1 and sw_cs_en=0, a control write that sets spi_en makes cs_oe=1 and cs_out=0 on the second clock edge after the write strobe is sampled. spi_en and master take the written values on the first such edge.
- R2: In drive mode, after spi_en is cleared, cs_out stays 0 for every edge at which busy=1 is sampled. It returns to 1 at the first edge that samples busy=0.
- R3: With master=1, hw_cs_oe=0 and sw_cs_en=0, cs_pin_in passes through a two-flop synchroniser. A low pin therefore sets mode_fault and clears spi_en and master on the third edge after the pin falls, and not before.
- R4: With sw_cs_en=1, cs_pin_in has no effect and sw_cs_lvl is the effective select. As master, sw_cs_lvl=0 sets mode_fault and clears spi_en and master at the next edge.
- R5: While mode_fault=1, a control write that tries to set spi_en or master leaves both at 0.
- R6: mode_fault clears only at a control write that comes after an earlier status access made while the flag was set. A control write with no status access before it leaves the flag set. A status access by itself also leaves the flag set.
- R7: irq is 1 exactly when mode_fault=1 and err_ie=1, and it follows err_ie with no clock delay.
- R8: As slave (master=0) with spi_en=1, selected=1 when the effective select is low: the synchronised pin (two edges of latency) when sw_cs_en=0, or sw_cs_lvl (no delay) when sw_cs_en=1. In every other case selected=0.
- R9: Outside drive mode, cs_oe=0 and cs_out is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_pin_in | input | 1 | Chip-select pin level, asynchronous |
| hw_cs_oe | input | 1 | Hardware chip-select output enable |
| sw_cs_en | input | 1 | Software select enable |
| sw_cs_lvl | input | 1 | Software select level |
| err_ie | input | 1 | Error interrupt enable |
| ctrl_wr | input | 1 | Control register write strobe |
| wr_spi_en | input | 1 | Port-enable value written by ctrl_wr |
| wr_master | input | 1 | Master bit value written by ctrl_wr |
| sts_access | input | 1 | Status register read or write strobe |
| busy | input | 1 | Transfer in progress |
| spi_en | output | 1 | Port enable bit |
| master | output | 1 | Master role bit |
| cs_out | output | 1 | Chip-select output level |
| cs_oe | output | 1 | Chip-select output enable |
| selected | output | 1 | Slave is selected |
| mode_fault | output | 1 | Sticky mode-fault flag |
| irq | output | 1 | Error interrupt |

## Verification
Each result has a fixed latency:
- Control writes reach spi_en and master one edge after the strobe.
- The chip-select drive registers add a second edge on top of that.
- A pin-triggered fault lands on the third edge, because the synchroniser sits in the path.
- A software-level fault lands on the first edge.
- irq, and slave selection in software mode, change without any edge.

The bench drives each input 1 ns after a rising edge. It then counts edges and reads the outputs at that same offset. It also checks the cycle just before each expected change, which catches a result that arrives early.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

    typedef struct packed {
        logic hw_oe;
        logic sw_en;
        logic sw_lvl;
        logic err_ie;
    } cs_cfg_t;

    typedef enum logic [1:0] {
        ROLE_SLAVE      = 2'd0,
        ROLE_MASTER_OUT = 2'd1,
        ROLE_MASTER_IN  = 2'd2
    } role_e;

    function automatic role_e role_of(input logic is_master, input cs_cfg_t c);
        if (!is_master)
            return ROLE_SLAVE;
        else if (c.hw_oe && !c.sw_en)
            return ROLE_MASTER_OUT;
        else
            return ROLE_MASTER_IN;
    endfunction

    function automatic logic eff_cs(input cs_cfg_t c, input logic pin_s);
        return c.sw_en ? c.sw_lvl : pin_s;
    endfunction

endpackage

// File: rtl/spi_cs_sync.sv
module spi_cs_sync #(
    parameter int    STAGES  = 2,
    parameter logic  RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= {STAGES{RST_VAL}};
        else
            chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

    initial begin
        stages_min_chk: assert (STAGES >= 2);
    end
endmodule

// File: rtl/spi_cs_mode.sv
module spi_cs_mode
    import spi_cs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  cs_cfg_t cfg,
    input  logic    pin_s,
    input  logic    ctrl_wr,
    input  logic    wr_spi_en,
    input  logic    wr_master,
    input  logic    sts_access,
    output logic    spi_en,
    output logic    master,
    output logic    fault_flag
);
    logic  en_q, mst_q, flag_q, armed_q;
    role_e role;
    logic  fault_hit;

    assign role      = role_of(mst_q, cfg);
    assign fault_hit = (role == ROLE_MASTER_IN) && !eff_cs(cfg, pin_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            mst_q   <= 1'b0;
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (fault_hit) begin
            en_q    <= 1'b0;
            mst_q   <= 1'b0;
            flag_q  <= 1'b1;
            armed_q <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                en_q  <= wr_spi_en & ~flag_q;
                mst_q <= wr_master & ~flag_q;
            end
            if (flag_q) begin
                if (ctrl_wr && armed_q) begin
                    flag_q  <= 1'b0;
                    armed_q <= 1'b0;
                end else if (sts_access) begin
                    armed_q <= 1'b1;
                end
            end else begin
                armed_q <= 1'b0;
            end
        end
    end

    assign spi_en     = en_q;
    assign master     = mst_q;
    assign fault_flag = flag_q;

    // R3 R4
    fault_entry_chk: assert property (@(posedge clk) disable iff (rst)
        fault_hit |=> (flag_q && !mst_q && !en_q));

    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !en_q && !mst_q) |=> (!en_q && !mst_q));

    // R6
    clear_order_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_q) |-> $past(ctrl_wr && armed_q));

    // R6
    unarmed_write_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q && ctrl_wr && !armed_q) |=> flag_q);
endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive
    import spi_cs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  role_e role,
    input  logic  spi_en,
    input  logic  busy,
    output logic  cs_out,
    output logic  cs_oe
);
    logic oe_q, low_q, drive_mode;

    assign drive_mode = (role == ROLE_MASTER_OUT);

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q  <= 1'b0;
            low_q <= 1'b0;
        end else begin
            oe_q  <= drive_mode;
            low_q <= drive_mode && (spi_en || (low_q && busy));
        end
    end

    assign cs_oe  = oe_q;
    assign cs_out = ~(oe_q & low_q);

    // R1
    drive_low_chk: assert property (@(posedge clk) disable iff (rst)
        (drive_mode && spi_en) |=> (cs_oe && !cs_out));

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (drive_mode && low_q && busy) |=> !cs_out);

    // R9
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_oe |-> cs_out);
endmodule

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl
    import spi_cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_pin_in,
    input  logic hw_cs_oe,
    input  logic sw_cs_en,
    input  logic sw_cs_lvl,
    input  logic err_ie,
    input  logic ctrl_wr,
    input  logic wr_spi_en,
    input  logic wr_master,
    input  logic sts_access,
    input  logic busy,
    output logic spi_en,
    output logic master,
    output logic cs_out,
    output logic cs_oe,
    output logic selected,
    output logic mode_fault,
    output logic irq
);
    cs_cfg_t cfg;
    logic    pin_s;
    role_e   role;

    assign cfg = '{hw_oe: hw_cs_oe, sw_en: sw_cs_en, sw_lvl: sw_cs_lvl, err_ie: err_ie};

    spi_cs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (cs_pin_in),
        .q   (pin_s)
    );

    spi_cs_mode u_mode (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .pin_s      (pin_s),
        .ctrl_wr    (ctrl_wr),
        .wr_spi_en  (wr_spi_en),
        .wr_master  (wr_master),
        .sts_access (sts_access),
        .spi_en     (spi_en),
        .master     (master),
        .fault_flag (mode_fault)
    );

    assign role = role_of(master, cfg);

    spi_cs_drive u_drive (
        .clk    (clk),
        .rst    (rst),
        .role   (role),
        .spi_en (spi_en),
        .busy   (busy),
        .cs_out (cs_out),
        .cs_oe  (cs_oe)
    );

    assign selected = (role == ROLE_SLAVE) && spi_en && !eff_cs(cfg, pin_s);
    assign irq      = mode_fault & cfg.err_ie;

    // R8
    slave_only_chk: assert property (@(posedge clk) disable iff (rst)
        selected |-> (!master && spi_en));

    // R7
    irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> mode_fault);
endmodule

// File: tb/spi_cs_ctrl_tb.sv
module spi_cs_ctrl_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_pin_in = 1'b1, hw_cs_oe = 1'b0, sw_cs_en = 1'b0, sw_cs_lvl = 1'b1;
    logic err_ie = 1'b0, ctrl_wr = 1'b0, wr_spi_en = 1'b0, wr_master = 1'b0;
    logic sts_access = 1'b0, busy = 1'b0;
    logic spi_en, master, cs_out, cs_oe, selected, mode_fault, irq;
    int   checks = 0;
    int   errors = 0;

    always #2.5 clk = ~clk;

    spi_cs_ctrl u_dut (
        .clk(clk), .rst(rst), .cs_pin_in(cs_pin_in), .hw_cs_oe(hw_cs_oe),
        .sw_cs_en(sw_cs_en), .sw_cs_lvl(sw_cs_lvl), .err_ie(err_ie),
        .ctrl_wr(ctrl_wr), .wr_spi_en(wr_spi_en), .wr_master(wr_master),
        .sts_access(sts_access), .busy(busy), .spi_en(spi_en), .master(master),
        .cs_out(cs_out), .cs_oe(cs_oe), .selected(selected),
        .mode_fault(mode_fault), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic ctrl_write(input logic en, input logic mst);
        ctrl_wr = 1'b1; wr_spi_en = en; wr_master = mst;
        tick();
        ctrl_wr = 1'b0;
    endtask

    task automatic sts_pulse();
        sts_access = 1'b1;
        tick();
        sts_access = 1'b0;
    endtask

    task automatic t_reset();
        chk("R9 reset cs_oe", cs_oe, 1'b0);
        chk("R9 reset cs_out", cs_out, 1'b1);
        chk("R5 reset spi_en", spi_en, 1'b0);
        chk("R3 reset mode_fault", mode_fault, 1'b0);
        chk("R7 reset irq", irq, 1'b0);
        chk("R8 reset selected", selected, 1'b0);
    endtask

    task automatic t_drive();
        hw_cs_oe = 1'b1; sw_cs_en = 1'b0;
        ctrl_write(1'b1, 1'b1);
        chk("R1 spi_en written", spi_en, 1'b1);
        chk("R1 master written", master, 1'b1);
        chk("R1 cs_oe one edge early", cs_oe, 1'b0);
        tick();
        chk("R1 cs_oe", cs_oe, 1'b1);
        chk("R1 cs_out low", cs_out, 1'b0);
        busy = 1'b1;
        ctrl_write(1'b0, 1'b1);
        chk("R2 spi_en cleared", spi_en, 1'b0);
        tick();
        chk("R2 hold while busy", cs_out, 1'b0);
        tick(); tick();
        chk("R2 still held", cs_out, 1'b0);
        busy = 1'b0;
        tick();
        chk("R2 released", cs_out, 1'b1);
        chk("R2 still driven", cs_oe, 1'b1);
        ctrl_write(1'b0, 1'b0);
        tick();
        chk("R9 oe off as slave", cs_oe, 1'b0);
        hw_cs_oe = 1'b0;
    endtask

    task automatic t_pin_fault();
        err_ie = 1'b1; cs_pin_in = 1'b1;
        ctrl_write(1'b1, 1'b1);
        tick(); tick();
        chk("R9 input-mode master oe", cs_oe, 1'b0);
        chk("R9 input-mode master out", cs_out, 1'b1);
        cs_pin_in = 1'b0;
        tick(); tick();
        chk("R3 no fault before sync", mode_fault, 1'b0);
        chk("R3 master kept before sync", master, 1'b1);
        tick();
        chk("R3 fault set", mode_fault, 1'b1);
        chk("R3 master cleared", master, 1'b0);
        chk("R3 spi_en cleared", spi_en, 1'b0);
        chk("R7 irq on", irq, 1'b1);
        err_ie = 1'b0; #1;
        chk("R7 irq masked", irq, 1'b0);
        err_ie = 1'b1; #1;
        chk("R7 irq back", irq, 1'b1);
    endtask

    task automatic t_lock_and_clear();
        ctrl_write(1'b1, 1'b1);
        chk("R5 spi_en locked", spi_en, 1'b0);
        chk("R5 master locked", master, 1'b0);
        cs_pin_in = 1'b1;
        ctrl_write(1'b0, 1'b0);
        chk("R6 write alone keeps flag", mode_fault, 1'b1);
        sts_pulse();
        chk("R6 status alone keeps flag", mode_fault, 1'b1);
        ctrl_write(1'b0, 1'b0);
        chk("R6 sequence clears flag", mode_fault, 1'b0);
        chk("R7 irq off", irq, 1'b0);
        ctrl_write(1'b1, 1'b0);
        chk("R5 unlock lets spi_en set", spi_en, 1'b1);
        ctrl_write(1'b0, 1'b0);
    endtask

    task automatic t_sw_fault();
        sw_cs_en = 1'b1; sw_cs_lvl = 1'b1; cs_pin_in = 1'b0;
        ctrl_write(1'b1, 1'b1);
        tick(); tick(); tick();
        chk("R4 pin ignored flag", mode_fault, 1'b0);
        chk("R4 pin ignored master", master, 1'b1);
        sw_cs_lvl = 1'b0;
        tick();
        chk("R4 sw fault", mode_fault, 1'b1);
        chk("R4 master cleared", master, 1'b0);
        sw_cs_lvl = 1'b1;
        sts_pulse();
        ctrl_write(1'b0, 1'b0);
        chk("R6 cleared after sw fault", mode_fault, 1'b0);
        sw_cs_en = 1'b0; cs_pin_in = 1'b1;
        tick(); tick();
    endtask

    task automatic t_slave();
        ctrl_write(1'b1, 1'b0);
        tick(); tick();
        chk("R8 pin high not selected", selected, 1'b0);
        cs_pin_in = 1'b0;
        tick();
        chk("R8 sync delay", selected, 1'b0);
        tick();
        chk("R8 pin low selected", selected, 1'b1);
        sw_cs_en = 1'b1; sw_cs_lvl = 1'b1; #1;
        chk("R8 sw level high", selected, 1'b0);
        sw_cs_lvl = 1'b0; #1;
        chk("R8 sw level low", selected, 1'b1);
        chk("R4 slave no fault", mode_fault, 1'b0);
        ctrl_write(1'b0, 1'b0);
        chk("R8 disabled", selected, 1'b0);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_drive();
        t_pin_fault();
        t_lock_and_clear();
        t_sw_fault();
        t_slave();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule